// File: doc/BRIEF.md
# Scaled-Displacement Effective Address Generator

This block forms the effective address of a load or store for a 32-bit CPU. A request carries an addressing mode, an access size and a displacement field, along with three operand values: the base register, the index register (R0) and the global-base register. The block picks the two operands that the mode calls for. It extends the displacement with zeros to the address width and, only in the modes that scale, multiplies it by the access size in bytes. It then adds the two operands modulo 2^32.

The sum is registered on the rising clock edge when the request strobe is high, and a valid flag goes with it. An alignment flag is registered at the same time. It reports a word address with bit 0 set, or a longword address with any of bits 1..0 set. The block leaves decoding, register reads, the memory access itself and any fault handling to its neighbours.

Top module: `disp_agu`

## Requirements
- R1: A synchronous active-high reset clears `eaValid`, `misalign` and `eaOut` (to zero) at the next rising edge.
- R2: Mode code 00 (short displacement) yields base + zero-extended `dispField[3:0]`, shifted left by 0, 1 or 2 for size codes 00 (byte), 01 (word) and 10 (longword).
- R3: Mode code 01 (long displacement) yields base + zero-extended `dispField[11:0]`, unscaled for every size code.
- R4: Mode code 10 (indexed) yields base + `indexVal`, whatever the size code and displacement field.
- R5: Mode code 11 (global base) yields `globalBase` + zero-extended `dispField[7:0]`, shifted left by 0, 1 or 2 for size codes 00, 01 and 10.
- R6: Size code 11 is reserved and behaves exactly as byte (no scaling, never misaligned).
- R7: In mode 00 the field bits 11..4 have no effect, and in mode 11 bits 11..8 have no effect.
- R8: Every addition wraps modulo 2^32 without any indication.
- R9: A request sampled high at a rising edge makes `eaValid` high with its address after that edge. A low request drops `eaValid` and `misalign` and leaves `eaOut` unchanged.
- R10: `misalign` is set with a valid result exactly when the size is word (01) and address bit 0 is 1, or the size is longword (10) and address bits 1..0 are nonzero. This applies in all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe; captures a new address |
| modeSel | input | 2 | Addressing mode: 00 short, 01 long, 10 indexed, 11 global base |
| sizeSel | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 reserved (byte) |
| dispField | input | 12 | Displacement field from the instruction |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register (R0) value |
| globalBase | input | 32 | Global-base register value |
| eaOut | output | 32 | Registered effective address |
| eaValid | output | 1 | High for the cycle after an accepted request |
| misalign | output | 1 | Registered alignment flag for the current result |

## Verification
The bench aims at the places where the modes differ. Long displacements are sent with word and longword sizes, so a design that scaled them would be off by a factor of two or four. Indexed requests carry nonzero displacements, so a design that let the displacement leak into that path shows it in the sum. Short and global-base requests carry set bits above the field width, and a design that failed to mask them would produce much larger addresses. Reserved-size requests and sums that wrap past the top of the address space go after a reserved code that scales, or a carry that is trimmed wrongly. Idle cycles between requests catch a valid flag that lingers and an address register that is not held.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_SHORT  = 2'b00,
    MODE_LONG   = 2'b01,
    MODE_INDEX  = 2'b10,
    MODE_GLOBAL = 2'b11
  } aguMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } aguSize_e;

  // which slice of the displacement field feeds the adder
  typedef enum logic [1:0] {
    DISP_NARROW = 2'b00,
    DISP_WIDE   = 2'b01,
    DISP_MID    = 2'b10,
    DISP_NONE   = 2'b11
  } dispSel_e;

  typedef struct packed {
    logic       load;
    logic       baseIsGlobal;
    logic       addIndex;
    dispSel_e   dispSel;
    logic [1:0] scaleLog2;
    logic [1:0] accessLog2;
  } aguStrobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] modeSel,
  input  logic [1:0] sizeSel,
  output aguStrobe_t strobe
);

  aguMode_e mode;
  aguSize_e size;
  logic [1:0] accLog2;

  assign mode = aguMode_e'(modeSel);
  assign size = aguSize_e'(sizeSel);

  always_comb begin
    unique case (size)
      SZ_WORD: accLog2 = 2'd1;
      SZ_LONG: accLog2 = 2'd2;
      default: accLog2 = 2'd0;
    endcase
  end

  always_comb begin
    strobe              = '0;
    strobe.load         = reqValid;
    strobe.accessLog2   = accLog2;
    strobe.baseIsGlobal = 1'b0;
    strobe.addIndex     = 1'b0;
    strobe.dispSel      = DISP_NONE;
    strobe.scaleLog2    = 2'd0;
    unique case (mode)
      MODE_SHORT: begin
        strobe.dispSel   = DISP_NARROW;
        strobe.scaleLog2 = accLog2;
      end
      MODE_LONG: begin
        strobe.dispSel   = DISP_WIDE;
      end
      MODE_INDEX: begin
        strobe.addIndex  = 1'b1;
      end
      MODE_GLOBAL: begin
        strobe.baseIsGlobal = 1'b1;
        strobe.dispSel      = DISP_MID;
        strobe.scaleLog2    = accLog2;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/agu_disp_unit.sv
module agu_disp_unit
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 12,
  parameter int NARROW_W = 4,
  parameter int MID_W    = 8
) (
  input  logic [DISP_W-1:0] dispField,
  input  dispSel_e          dispSel,
  input  logic [1:0]        scaleLog2,
  output logic [ADDR_W-1:0] dispOffset
);

  localparam int NARROW_PAD = ADDR_W - NARROW_W;
  localparam int MID_PAD    = ADDR_W - MID_W;
  localparam int WIDE_PAD   = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] narrowExt, midExt, wideExt, picked;

  generate
    if (NARROW_PAD > 0) begin : g_narrowPad
      assign narrowExt = {{NARROW_PAD{1'b0}}, dispField[NARROW_W-1:0]};
    end else begin : g_narrowFull
      assign narrowExt = dispField[ADDR_W-1:0];
    end
    if (MID_PAD > 0) begin : g_midPad
      assign midExt = {{MID_PAD{1'b0}}, dispField[MID_W-1:0]};
    end else begin : g_midFull
      assign midExt = dispField[ADDR_W-1:0];
    end
    if (WIDE_PAD > 0) begin : g_widePad
      assign wideExt = {{WIDE_PAD{1'b0}}, dispField};
    end else begin : g_wideFull
      assign wideExt = dispField[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (dispSel)
      DISP_NARROW: picked = narrowExt;
      DISP_WIDE:   picked = wideExt;
      DISP_MID:    picked = midExt;
      default:     picked = '0;
    endcase
  end

  always_comb begin
    unique case (scaleLog2)
      2'd1:    dispOffset = {picked[ADDR_W-2:0], 1'b0};
      2'd2:    dispOffset = {picked[ADDR_W-3:0], 2'b00};
      default: dispOffset = picked;
    endcase
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DISP_W      = 12,
  parameter int NARROW_W    = 4,
  parameter int MID_W       = 8,
  parameter bit MISALIGN_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  aguStrobe_t        strobe,
  input  logic [DISP_W-1:0] dispField,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] globalBase,
  output logic [ADDR_W-1:0] eaOut,
  output logic              eaValid,
  output logic              misalign
);

  logic [ADDR_W-1:0] dispOffset, operandA, operandB, sum;
  logic              misNext;

  agu_disp_unit #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .NARROW_W(NARROW_W),
    .MID_W   (MID_W)
  ) dispUnit_i (
    .dispField (dispField),
    .dispSel   (strobe.dispSel),
    .scaleLog2 (strobe.scaleLog2),
    .dispOffset(dispOffset)
  );

  assign operandA = strobe.baseIsGlobal ? globalBase : baseVal;
  assign operandB = strobe.addIndex ? indexVal : dispOffset;
  assign sum      = operandA + operandB;

  generate
    if (MISALIGN_EN) begin : g_alignCheck
      always_comb begin
        unique case (strobe.accessLog2)
          2'd1:    misNext = sum[0];
          2'd2:    misNext = |sum[1:0];
          default: misNext = 1'b0;
        endcase
      end
    end else begin : g_noAlignCheck
      assign misNext = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      eaOut    <= '0;
      eaValid  <= 1'b0;
      misalign <= 1'b0;
    end else begin
      eaValid  <= strobe.load;
      misalign <= strobe.load & misNext;
      if (strobe.load) eaOut <= sum;
    end
  end

endmodule

// File: rtl/disp_agu.sv
module disp_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DISP_W      = 12,
  parameter int NARROW_W    = 4,
  parameter int MID_W       = 8,
  parameter bit MISALIGN_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        sizeSel,
  input  logic [DISP_W-1:0] dispField,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] globalBase,
  output logic [ADDR_W-1:0] eaOut,
  output logic              eaValid,
  output logic              misalign
);

  aguStrobe_t strobe;

  agu_ctrl ctrl_i (
    .reqValid(reqValid),
    .modeSel (modeSel),
    .sizeSel (sizeSel),
    .strobe  (strobe)
  );

  agu_datapath #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .NARROW_W   (NARROW_W),
    .MID_W      (MID_W),
    .MISALIGN_EN(MISALIGN_EN)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .dispField (dispField),
    .baseVal   (baseVal),
    .indexVal  (indexVal),
    .globalBase(globalBase),
    .eaOut     (eaOut),
    .eaValid   (eaValid),
    .misalign  (misalign)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [1:0]        modeSel,
  input logic [1:0]        sizeSel,
  input logic [DISP_W-1:0] dispField,
  input logic [ADDR_W-1:0] baseVal,
  input logic [ADDR_W-1:0] indexVal,
  input logic [ADDR_W-1:0] eaOut,
  input logic              eaValid,
  input logic              misalign
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!eaValid && !misalign && eaOut == '0));

  assert_req_sets_valid_R9: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> eaValid);

  assert_idle_drops_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!eaValid && !misalign));

  assert_idle_holds_addr_R9: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $stable(eaOut));

  assert_long_unscaled_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && modeSel == 2'b01) |=>
      (eaOut == $past(baseVal) + ADDR_W'($past(dispField))));

  assert_indexed_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && modeSel == 2'b10) |=>
      (eaOut == $past(baseVal) + $past(indexVal)));

  assert_flag_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    misalign |-> eaValid);

  assert_byte_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (sizeSel == 2'b00 || sizeSel == 2'b11)) |=> !misalign);

endmodule

bind disp_agu agu_checker #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .modeSel  (modeSel),
  .sizeSel  (sizeSel),
  .dispField(dispField),
  .baseVal  (baseVal),
  .indexVal (indexVal),
  .eaOut    (eaOut),
  .eaValid  (eaValid),
  .misalign (misalign)
);

// File: tb/disp_agu_tb_top.sv
`timescale 1ns/1ps
module disp_agu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [11:0] dispField = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] indexVal = '0;
  logic [31:0] globalBase = '0;
  logic [31:0] eaOut;
  logic        eaValid;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expEa = '0;
  logic        expValid = 1'b0;
  logic        expMis = 1'b0;

  always #5 clk = ~clk;

  disp_agu dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .modeSel(modeSel),
    .sizeSel(sizeSel), .dispField(dispField), .baseVal(baseVal),
    .indexVal(indexVal), .globalBase(globalBase), .eaOut(eaOut),
    .eaValid(eaValid), .misalign(misalign)
  );

  function automatic logic [31:0] refEa(input logic [1:0] m, input logic [1:0] s,
      input logic [11:0] d, input logic [31:0] b, input logic [31:0] x,
      input logic [31:0] g);
    int sc;
    logic [31:0] r;
    sc = (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
    case (m)
      2'b00:   r = b + ((32'(d) & 32'hF) << sc);
      2'b01:   r = b + 32'(d);
      2'b10:   r = b + x;
      default: r = g + ((32'(d) & 32'hFF) << sc);
    endcase
    return r;
  endfunction

  function automatic logic refMis(input logic [1:0] s, input logic [31:0] a);
    if (s == 2'b01) return a[0];
    if (s == 2'b10) return a[1] | a[0];
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, edge, update model, compare
  task automatic cycle(input logic req, input logic [1:0] m, input logic [1:0] s,
      input logic [11:0] d, input logic [31:0] b, input logic [31:0] x,
      input logic [31:0] g, input string tag);
    reqValid = req; modeSel = m; sizeSel = s; dispField = d;
    baseVal = b; indexVal = x; globalBase = g;
    @(posedge clk);
    if (rst) begin
      expEa = '0; expValid = 1'b0; expMis = 1'b0;
    end else if (req) begin
      expEa = refEa(m, s, d, b, x, g); expValid = 1'b1; expMis = refMis(s, expEa);
    end else begin
      expValid = 1'b0; expMis = 1'b0;
    end
    #2;
    check({tag, " valid"}, 32'(eaValid), 32'(expValid));
    check({tag, " addr"}, eaOut, expEa);
    check({tag, " R10 misalign"}, 32'(misalign), 32'(expMis));
  endtask

  task automatic req(input logic [1:0] m, input logic [1:0] s, input logic [11:0] d,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] g, input string tag);
    cycle(1'b1, m, s, d, b, x, g, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rst = 1'b1;
    cycle(1'b1, 2'b01, 2'b00, 12'hABC, 32'h1234, 0, 0, "R1 reset");
    cycle(1'b0, 0, 0, 0, 0, 0, 0, "R1 reset");
    rst = 1'b0;

    // R2 short displacement, each size
    req(2'b00, 2'b00, 12'h00F, 32'h1000, 32'h55, 32'h9000, "R2 byte");
    req(2'b00, 2'b01, 12'h00F, 32'h1000, 32'h55, 32'h9000, "R2 word");
    req(2'b00, 2'b10, 12'h00F, 32'h1000, 32'h55, 32'h9000, "R2 long");
    // R3 long displacement never scaled
    req(2'b01, 2'b00, 12'hFFF, 32'h2000, 32'h55, 32'h9000, "R3 byte");
    req(2'b01, 2'b01, 12'h801, 32'h2000, 32'h55, 32'h9000, "R3 word");
    req(2'b01, 2'b10, 12'h803, 32'h2000, 32'h55, 32'h9000, "R3 long");
    // R4 indexed ignores size and displacement
    req(2'b10, 2'b00, 12'hFFF, 32'h3000, 32'h123, 32'h9000, "R4 byte");
    req(2'b10, 2'b10, 12'h0A5, 32'h3000, 32'h124, 32'h9000, "R4 long");
    req(2'b10, 2'b01, 12'h777, 32'h3001, 32'h0, 32'h9000, "R4 word");
    // R5 global base, each size
    req(2'b11, 2'b00, 12'h0FF, 32'h4000, 32'h55, 32'h8000, "R5 byte");
    req(2'b11, 2'b01, 12'h0FF, 32'h4000, 32'h55, 32'h8000, "R5 word");
    req(2'b11, 2'b10, 12'h0FF, 32'h4000, 32'h55, 32'h8000, "R5 long");
    // R6 reserved size behaves as byte
    req(2'b00, 2'b11, 12'h007, 32'h1001, 32'h0, 32'h0, "R6 short");
    req(2'b11, 2'b11, 12'h0C3, 32'h0, 32'h0, 32'h8001, "R6 global");
    // R7 upper field bits ignored
    req(2'b00, 2'b10, 12'hFF3, 32'h1000, 32'h0, 32'h0, "R7 short");
    req(2'b11, 2'b01, 12'hF81, 32'h0, 32'h0, 32'h8000, "R7 global");
    // R8 wraparound
    req(2'b11, 2'b10, 12'h0FF, 32'h0, 32'h0, 32'hFFFF_FF00, "R8 global wrap");
    req(2'b01, 2'b00, 12'hFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, "R8 long wrap");
    req(2'b10, 2'b00, 12'h0, 32'h8000_0000, 32'h8000_0004, 32'h0, "R8 index wrap");
    // R9 idle cycles drop valid and hold the address
    cycle(1'b0, 2'b01, 2'b00, 12'h111, 32'h5555, 0, 0, "R9 idle");
    cycle(1'b0, 2'b10, 2'b10, 12'h222, 32'h6666, 32'h1, 0, "R9 idle");
    // R10 misalignment patterns
    req(2'b01, 2'b01, 12'h001, 32'h2000, 0, 0, "R10 word odd");
    req(2'b01, 2'b10, 12'h002, 32'h2000, 0, 0, "R10 long bit1");
    req(2'b01, 2'b10, 12'h004, 32'h2000, 0, 0, "R10 long aligned");
    req(2'b01, 2'b00, 12'h001, 32'h2000, 0, 0, "R10 byte odd");
    req(2'b10, 2'b01, 12'h0, 32'h2000, 32'h2, 0, "R10 word even");
    // mixed stream
    for (int k = 0; k < 300; k++) begin
      logic [1:0] m;
      logic [1:0] s;
      logic r;
      string tag;
      m = 2'($urandom); s = 2'($urandom); r = ($urandom % 4) != 0;
      tag = !r ? "R9 mix idle" : (s == 2'b11) ? "R6 mix" :
            (m == 2'b00) ? "R2 mix" : (m == 2'b01) ? "R3 mix" :
            (m == 2'b10) ? "R4 mix" : "R5 mix";
      cycle(r, m, s, 12'($urandom), $urandom, $urandom, $urandom, tag);
    end
    // R1 reset in mid-run
    rst = 1'b1;
    cycle(1'b1, 2'b10, 2'b01, 0, 32'h77, 32'h1, 0, "R1 mid reset");
    rst = 1'b0;
    cycle(1'b0, 0, 0, 0, 0, 0, 0, "R1 after reset");
    finishRun();
  end

endmodule